// File: doc/BRIEF.md
# Relative Branch Evaluator

This block resolves a relative branch instruction in a single clock. When `start` is pulsed, it looks at the 16-bit opcode and the four condition flags. From them it decides whether control moves to a target address.

The displacement comes from the low byte of the opcode. When that byte is zero, a 16-bit extension word supplies the displacement instead. The block produces the next program counter and a taken indication. It also gives the number of bus cycles the instruction costs.

One condition code selects a subroutine-call form, which is always taken. This form lowers the stack pointer by four and issues a single 32-bit stack write request holding the return address. The fetch logic around the block supplies `pc_in`, which is the address of the word that follows the opcode.

Top module: `branch_eval`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `start`, `done`, `push_valid` and `taken` are 0, and `pc_out`, `sp_out` and `cycles` are 0.
- R2: When opcode bits 7:0 are nonzero, they are a two's-complement displacement. A taken branch goes to `pc_in` plus that value sign-extended to 32 bits, and a not-taken branch goes to `pc_in`.
- R3: When opcode bits 7:0 are zero, the sign-extended `ext_word` is the displacement. A taken branch goes to `pc_in + ext`, and a not-taken branch goes to `pc_in + 2`, which is the address past the extension word.
- R4: Opcode bits 11:8 select the condition. `nzvc` carries N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. Code 0 is always taken. The remaining flag-test codes are: 4 taken when C=0, 5 when C=1, 6 when Z=0, 7 when Z=1, 8 when V=0, 9 when V=1, 10 when N=0, 11 when N=1.
- R5: Signed comparisons: code 12 is taken when N==V, and code 13 when N!=V. Code 14 is taken when N==V and Z=0. Code 15 is taken when Z=1 or N!=V.
- R6: Unsigned comparisons: code 2 is taken when C=0 and Z=0, and code 3 when C=1 or Z=1.
- R7: Code 1 is a call and is always taken. `sp_out` is `sp_in - 4`, `push_addr` equals `sp_out`, and `push_data` is the return address: `pc_in` for the short form, `pc_in + 2` for the long form. `push_valid` is high for exactly the one clock in which `done` is high.
- R8: `cycles` is 10 for a taken branch and 18 for a call. It is 8 for a not-taken short branch and 12 for a not-taken long branch.
- R9: Results appear, and `done` pulses for one clock, on the edge after the edge that samples `start`. All result outputs hold until the next `start`.
- R10: All address arithmetic wraps modulo 2^32.
- R11: Codes other than 1 never raise `push_valid` and leave `sp_out` equal to `sp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the presented instruction |
| opcode | input | 16 | Branch opcode |
| ext_word | input | 16 | Extension displacement word |
| pc_in | input | 32 | Address following the opcode |
| sp_in | input | 32 | Current stack pointer |
| nzvc | input | 4 | Condition flags N,Z,V,C |
| done | output | 1 | Result valid pulse |
| taken | output | 1 | Branch was taken |
| pc_out | output | 32 | Next program counter |
| sp_out | output | 32 | Next stack pointer |
| push_valid | output | 1 | Stack write request strobe |
| push_addr | output | 32 | Stack write address |
| push_data | output | 32 | Stack write data (return address) |
| cycles | output | 5 | Cycle cost of the instruction |

## Verification
On every cycle the assertions check several properties. Each result follows a `start`, and a stack push coincides with `done` and targets the lowered stack pointer. Non-call branches leave the stack pointer alone, and the cycle cost is one of the four legal values, consistent with the taken indication. Only the directed scenarios can show the rest. That covers the per-condition truth tables for each flag combination and the exact target arithmetic, including long-form offsets and 32-bit wraparound. It also covers the return address the call form pushes.

// File: rtl/branch_eval.sv
module branch_eval #(
  parameter int AW    = 32,
  parameter int CYC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      opcode,
  input  logic [15:0]      ext_word,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    sp_in,
  input  logic [3:0]       nzvc,
  output logic             done,
  output logic             taken,
  output logic [AW-1:0]    pc_out,
  output logic [AW-1:0]    sp_out,
  output logic             push_valid,
  output logic [AW-1:0]    push_addr,
  output logic [AW-1:0]    push_data,
  output logic [CYC_W-1:0] cycles
);
  localparam logic [CYC_W-1:0] C_TAKEN = CYC_W'(10);
  localparam logic [CYC_W-1:0] C_CALL  = CYC_W'(18);
  localparam logic [CYC_W-1:0] C_SKIP  = CYC_W'(8);
  localparam logic [CYC_W-1:0] C_LONG  = CYC_W'(4);
  localparam logic [AW-1:0]    PUSH_SZ = AW'(4);

  wire f_n = nzvc[3];
  wire f_z = nzvc[2];
  wire f_v = nzvc[1];
  wire f_c = nzvc[0];

  wire [3:0] code      = opcode[11:8];
  wire       long_form = (opcode[7:0] == 8'h00);
  wire       is_call   = (code == 4'd1);

  wire [AW-1:0] disp   = long_form ? {{(AW-16){ext_word[15]}}, ext_word}
                                   : {{(AW-8){opcode[7]}}, opcode[7:0]};
  wire [AW-1:0] seq_pc = pc_in + (long_form ? AW'(2) : AW'(0));
  wire [AW-1:0] target = pc_in + disp;

  logic go;
  always_comb begin
    unique case (code)
      4'd0, 4'd1: go = 1'b1;
      4'd2:  go = !f_c && !f_z;
      4'd3:  go = f_c || f_z;
      4'd4:  go = !f_c;
      4'd5:  go = f_c;
      4'd6:  go = !f_z;
      4'd7:  go = f_z;
      4'd8:  go = !f_v;
      4'd9:  go = f_v;
      4'd10: go = !f_n;
      4'd11: go = f_n;
      4'd12: go = (f_n == f_v);
      4'd13: go = (f_n != f_v);
      4'd14: go = (f_n == f_v) && !f_z;
      default: go = f_z || (f_n != f_v);
    endcase
  end

  logic [CYC_W-1:0] cost;
  always_comb begin
    if (is_call)        cost = C_CALL;
    else if (go)        cost = C_TAKEN;
    else if (long_form) cost = C_SKIP + C_LONG;
    else                cost = C_SKIP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      taken      <= 1'b0;
      pc_out     <= '0;
      sp_out     <= '0;
      push_valid <= 1'b0;
      push_addr  <= '0;
      push_data  <= '0;
      cycles     <= '0;
    end else begin
      done       <= start;
      push_valid <= start && is_call;
      if (start) begin
        taken  <= go;
        pc_out <= go ? target : seq_pc;
        sp_out <= is_call ? sp_in - PUSH_SZ : sp_in;
        cycles <= cost;
        if (is_call) begin
          push_addr <= sp_in - PUSH_SZ;
          push_data <= seq_pc;
        end
      end
    end
  end

  a_r9_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  a_r7_push_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (done && taken && push_addr == sp_out));
  a_r7_sp_lowered: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (sp_out == $past(sp_in) - PUSH_SZ));
  a_r11_sp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !push_valid) |-> (sp_out == $past(sp_in)));
  a_r8_cost_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (taken ? (cycles == C_TAKEN || cycles == C_CALL)
                    : (cycles == C_SKIP || cycles == C_SKIP + C_LONG)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> ($stable(pc_out) && $stable(sp_out) && $stable(cycles)));
endmodule

// File: tb/branch_eval_test.sv
module branch_eval_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [15:0] opcode = 0, ext_word = 0;
  logic [31:0] pc_in = 0, sp_in = 0;
  logic [3:0]  nzvc = 0;
  logic        done, taken, push_valid;
  logic [31:0] pc_out, sp_out, push_addr, push_data;
  logic [4:0]  cycles;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_eval uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .ext_word(ext_word),
    .pc_in(pc_in), .sp_in(sp_in), .nzvc(nzvc), .done(done), .taken(taken),
    .pc_out(pc_out), .sp_out(sp_out), .push_valid(push_valid), .push_addr(push_addr),
    .push_data(push_data), .cycles(cycles)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic bit want(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], v = f[1], cy = f[0];
    case (c)
      0, 1: return 1;
      2: return !cy && !z;   3: return cy || z;
      4: return !cy;         5: return cy;
      6: return !z;          7: return z;
      8: return !v;          9: return v;
      10: return !n;         11: return n;
      12: return n == v;     13: return n != v;
      14: return (n == v) && !z;
      default: return z || (n != v);
    endcase
  endfunction

  task automatic issue(input logic [15:0] op, input logic [15:0] ext, input logic [31:0] pc,
                       input logic [31:0] sp, input logic [3:0] f);
    @(negedge clk);
    opcode = op; ext_word = ext; pc_in = pc; sp_in = sp; nzvc = f; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_one(input string req, input logic [15:0] op, input logic [15:0] ext,
                         input logic [31:0] pc, input logic [31:0] sp, input logic [3:0] f);
    bit lf = (op[7:0] == 0);
    bit tk = want(op[11:8], f);
    bit call = (op[11:8] == 1);
    logic [31:0] d = lf ? {{16{ext[15]}}, ext} : {{24{op[7]}}, op[7:0]};
    logic [31:0] nxt = lf ? pc + 2 : pc;
    issue(op, ext, pc, sp, f);
    chk(req, "done", done, 1);
    chk(req, "taken", taken, tk);
    chk(req, "pc", pc_out, tk ? pc + d : nxt);
    chk(req, "sp", sp_out, call ? sp - 4 : sp);
    chk(req, "push_valid", push_valid, call);
    if (call) begin
      chk(req, "push_addr", push_addr, sp - 4);
      chk(req, "push_data", push_data, nxt);
    end
    chk(req, "cycles", cycles, call ? 18 : tk ? 10 : lf ? 12 : 8);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R1", "done", done, 0);
    chk("R1", "push_valid", push_valid, 0);
    chk("R1", "pc_out", pc_out, 0);
    chk("R1", "cycles", cycles, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "done idle", done, 0);
  endtask

  task automatic t_short;
    run_one("R2", 16'h6010, 16'hFFFF, 32'h0000_1000, 32'h8000, 4'h0);
    run_one("R2", 16'h60F0, 16'h1234, 32'h0000_1000, 32'h8000, 4'h0);
    run_one("R2", 16'h6780, 16'h0000, 32'h0000_2000, 32'h8000, 4'h0);
  endtask

  task automatic t_long;
    run_one("R3", 16'h6000, 16'h7FFE, 32'h0000_4000, 32'h8000, 4'h0);
    run_one("R3", 16'h6000, 16'h8000, 32'h0001_0000, 32'h8000, 4'h0);
    run_one("R3", 16'h6700, 16'h0100, 32'h0000_3000, 32'h8000, 4'h0);
  endtask

  task automatic t_simple;
    for (int c = 4; c <= 11; c++)
      for (int f = 0; f < 16; f++)
        run_one("R4", {4'h6, c[3:0], 8'h22}, 16'h0, 32'h100, 32'h8000, f[3:0]);
  endtask

  task automatic t_signed;
    for (int c = 12; c <= 15; c++)
      for (int f = 0; f < 16; f++)
        run_one("R5", {4'h6, c[3:0], 8'h00}, 16'hFF00, 32'h500, 32'h8000, f[3:0]);
  endtask

  task automatic t_unsigned;
    for (int c = 2; c <= 3; c++)
      for (int f = 0; f < 16; f++)
        run_one("R6", {4'h6, c[3:0], 8'hFE}, 16'h0, 32'h700, 32'h9000, f[3:0]);
  endtask

  task automatic t_call;
    run_one("R7", 16'h6108, 16'h0, 32'h0000_1200, 32'h0000_7000, 4'hF);
    run_one("R7", 16'h6100, 16'h0040, 32'h0000_1200, 32'h0000_7000, 4'h0);
    @(negedge clk);
    chk("R7", "push one clock", push_valid, 0);
    chk("R9", "done one clock", done, 0);
    chk("R9", "pc held", pc_out, 32'h0000_1240);
    chk("R9", "sp held", sp_out, 32'h0000_6FFC);
  endtask

  task automatic t_wrap;
    run_one("R10", 16'h6020, 16'h0, 32'hFFFF_FFF0, 32'h8000, 4'h0);
    run_one("R10", 16'h6000, 16'hFFF0, 32'h0000_0004, 32'h8000, 4'h0);
    run_one("R10", 16'h6104, 16'h0, 32'h0000_0100, 32'h0000_0002, 4'h0);
  endtask

  task automatic t_nopush;
    run_one("R11", 16'h6E00, 16'h0010, 32'h300, 32'hABCD_0000, 4'h4);
    chk("R11", "no push", push_valid, 0);
    run_one("R8", 16'h6700, 16'h0010, 32'h300, 32'h1000, 4'h0);
    run_one("R8", 16'h6708, 16'h0, 32'h300, 32'h1000, 4'h0);
  endtask

  initial begin
    fork
      begin
        t_reset; t_short; t_long; t_simple; t_signed; t_unsigned;
        t_call; t_wrap; t_nopush;
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule